// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block is the data path of an SPI master. It takes 32-bit words from a transmit FIFO and shifts each one out on MOSI. Bytes go least significant byte first, and within each byte the most significant bit goes first. The engine captures MISO in parallel and packs the received bytes into a 32-bit word, which it pushes into a receive FIFO. The SPI clock comes from a programmable divider of the system clock, and the bus runs in mode 0.

The transfer length is set in bits, not in words. A signed countdown of the bits still to send is reloaded only when a new word is popped and the countdown has already run out. A long burst therefore spans several words, and a short burst sends only as many bytes as it needs from each word. A multi-burst mode decides what happens when a burst ends. In that mode the engine starts a new burst on the next word. Otherwise it stops, even if words are still waiting.

A start pulse launches an exchange. The engine reports its progress with a busy level, an exchange-busy level and single-cycle pulses for completion and receive overflow.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, `sclk`, `busy`, `xch_busy`, `tx_pop`, `rx_push`, `evt_done` and `evt_ovf` are all low.
- R2: A burst is `cfg_len + 1` bits long. When a word is popped, the remaining-bits count is reloaded with the burst length only if the count is zero or negative. Otherwise the count left over from the previous word carries on.
- R3: A popped word sends min(remaining, 32) bits, rounded up to whole bytes. Bytes are taken from the word's bits [7:0] first, then [15:8], and so on. Each byte goes out most significant bit first in mode 0: `sclk` idles low, MOSI changes only while `sclk` is low, and MISO is sampled on the rising edge.
- R4: The byte received during the n-th byte of a word lands at bits 8n+7..8n of `rx_data`. Bytes that are not exchanged read as zero.
- R5: At the end of each word, the received word is pushed (`rx_push`) if `rx_full` is low. If `rx_full` is high, the word is dropped and `evt_ovf` pulses instead.
- R6: Multi-burst mode holds when `cfg_master` is high, `cfg_imm` is low and `cfg_hold[cfg_chan]` is high. In that mode, `xch_busy` rises when a popped word reloads the count.
- R7: When the count reaches zero or below at the end of a word, `xch_busy` clears. Without multi-burst mode, `evt_done` then pulses and the engine stops, leaving any remaining words in the FIFO.
- R8: If the transmit FIFO is empty at the end of a word, `evt_done` pulses and the engine stops. A start with an empty FIFO pulses `evt_done` at once and pops nothing.
- R9: A start pulse while `cfg_master` is low is ignored: nothing is popped, no event is raised, and `busy` stays low.
- R10: Each `sclk` half period lasts `cfg_div + 1` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches an exchange |
| cfg_master | input | 1 | The selected channel acts as master |
| cfg_imm | input | 1 | Immediate-start mode; disables multi-burst |
| cfg_chan | input | CH_W | Selected channel |
| cfg_hold | input | NCH | Select-hold bit per channel |
| cfg_len | input | LEN_W | Burst length in bits, minus one |
| cfg_div | input | DIV_W | SCLK half period in clock cycles, minus one |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_pop | output | 1 | Pops the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Pushes `rx_data` into the receive FIFO |
| rx_data | output | 32 | Assembled receive word |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| xch_busy | output | 1 | Exchange-busy level |
| busy | output | 1 | Engine is not idle |
| evt_done | output | 1 | Transfer-complete pulse |
| evt_ovf | output | 1 | Receive-overflow pulse |

## Verification
The properties assume that the transmit FIFO behaves as a FIFO. Once `tx_valid` is high, it stays high and `tx_data` stays stable until `tx_pop` takes the word. The configuration inputs are held steady for the whole of an exchange. The bench models both FIFOs as arrays that change only on a pop or a push, and it writes new configuration and words only while `busy` is low. `rx_full` is held constant for each run, so the bench can state in advance whether each word is pushed or dropped.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int REM_W = 16;
  typedef logic signed [REM_W-1:0] rem_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POP, ST_BYTE_GO, ST_BYTE_WAIT, ST_WORD_END
  } eng_state_t;

  // Burst length in bits: configured field plus one.
  function automatic rem_t burst_bits(input logic [13:0] field);
    return $signed({2'b00, field}) + 16'sd1;
  endfunction

  // Bits a single word may carry: capped at one full word.
  function automatic rem_t word_bits(input rem_t rem);
    return (rem > 16'sd32) ? 16'sd32 : rem;
  endfunction

  // Drop a received byte into lane idx of the receive word.
  function automatic logic [31:0] place_byte(input logic [31:0] w,
                                             input logic [1:0] idx,
                                             input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[{idx, 3'b000} +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == div);
endmodule

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] din,
  input  logic       tick,
  input  logic       miso,
  output logic       active,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] dout
);
  logic [7:0] tx_sh;
  logic [2:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      tx_sh   <= '0;
      dout    <= '0;
      bit_cnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active  <= 1'b1;
        sclk    <= 1'b0;
        tx_sh   <= din;
        bit_cnt <= '0;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
          dout <= {dout[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            tx_sh   <= {tx_sh[6:0], 1'b0};
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
      end
    end
  end

  assign mosi = tx_sh[7];
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int DIV_W = 8,
  parameter int NCH   = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PAD  = 14 - LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_master,
  input  logic             cfg_imm,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [NCH-1:0]   cfg_hold,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tx_valid,
  input  logic [31:0]      tx_data,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [31:0]      rx_data,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             xch_busy,
  output logic             busy,
  output logic             evt_done,
  output logic             evt_ovf
);
  eng_state_t  state;
  logic [31:0] txw, rxw;
  rem_t        rem, wb, rem_ld;
  logic [1:0]  idx;
  logic        xch;

  // Named internal events, observed by the checker.
  logic multi, byte_go, byte_done, byte_active, tick, word_end, stop_now, rem_spent;
  logic [7:0] byte_dout;

  assign multi     = cfg_master && !cfg_imm && cfg_hold[cfg_chan];
  assign rem_spent = (rem <= 16'sd0);
  assign rem_ld    = rem_spent ? burst_bits({{PAD{1'b0}}, cfg_len}) : rem;
  assign word_end  = (state == ST_WORD_END);
  assign stop_now  = word_end && ((rem_spent && !multi) || !tx_valid);
  assign byte_go   = (state == ST_BYTE_GO);

  spi_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(byte_active), .div(cfg_div), .tick(tick)
  );

  spi_byte_xfer u_byte (
    .clk(clk), .rst_n(rst_n), .go(byte_go), .din(txw[7:0]), .tick(tick),
    .miso(miso), .active(byte_active), .sclk(sclk), .mosi(mosi),
    .done(byte_done), .dout(byte_dout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      txw   <= '0;
      rxw   <= '0;
      rem   <= '0;
      wb    <= '0;
      idx   <= '0;
      xch   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start && cfg_master && tx_valid) state <= ST_POP;
        end
        ST_POP: begin
          rem <= rem_ld;
          wb  <= word_bits(rem_ld);
          if (rem_spent && multi) xch <= 1'b1;
          txw   <= tx_data;
          rxw   <= '0;
          idx   <= '0;
          state <= ST_BYTE_GO;
        end
        ST_BYTE_GO: state <= ST_BYTE_WAIT;
        ST_BYTE_WAIT: begin
          if (byte_done) begin
            rxw <= place_byte(rxw, idx, byte_dout);
            txw <= txw >> 8;
            wb  <= wb - 16'sd8;
            rem <= rem - 16'sd8;
            idx <= idx + 2'd1;
            state <= ((wb - 16'sd8) <= 16'sd0) ? ST_WORD_END : ST_BYTE_GO;
          end
        end
        ST_WORD_END: begin
          if (rem_spent) xch <= 1'b0;
          state <= stop_now ? ST_IDLE : ST_POP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_pop   = (state == ST_POP);
  assign rx_push  = word_end && !rx_full;
  assign evt_ovf  = word_end && rx_full;
  assign evt_done = ((state == ST_IDLE) && start && cfg_master && !tx_valid) || stop_now;
  assign rx_data  = rxw;
  assign xch_busy = xch;
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic tx_pop,
  input logic tx_valid,
  input logic rx_push,
  input logic rx_full,
  input logic evt_ovf,
  input logic evt_done,
  input logic xch_busy,
  input logic word_end
);
  a_r3_sclk_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);

  a_r3_mosi_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sclk);

  a_r3_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);

  a_r5_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  a_r5_ovf_at_word_end: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |-> (word_end && !rx_push));

  a_r6_xch_rise_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xch_busy) |-> $past(tx_pop));

  a_r8_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !busy);
endmodule

bind spi_burst_engine spi_burst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .busy(busy),
  .tx_pop(tx_pop), .tx_valid(tx_valid), .rx_push(rx_push), .rx_full(rx_full),
  .evt_ovf(evt_ovf), .evt_done(evt_done), .xch_busy(xch_busy),
  .word_end(word_end)
);

// File: tb/tb_spi_burst_engine.sv
`timescale 1ns/1ps
module tb_spi_burst_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start = 1'b0, cfg_master = 1'b1, cfg_imm = 1'b0;
  logic [1:0]  cfg_chan = 2'd0;
  logic [3:0]  cfg_hold = 4'd0;
  logic [11:0] cfg_len = 12'd31;
  logic [7:0]  cfg_div = 8'd1;
  logic        tx_valid, tx_pop, rx_full = 1'b0, rx_push;
  logic [31:0] tx_data, rx_data;
  logic        sclk, mosi, miso, xch_busy, busy, evt_done, evt_ovf;

  spi_burst_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_master(cfg_master),
    .cfg_imm(cfg_imm), .cfg_chan(cfg_chan), .cfg_hold(cfg_hold),
    .cfg_len(cfg_len), .cfg_div(cfg_div), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .xch_busy(xch_busy), .busy(busy), .evt_done(evt_done), .evt_ovf(evt_ovf)
  );

  int total = 0, bad = 0;

  // Transmit FIFO model
  logic [31:0] txq [0:255];
  int head = 0, tail = 0;
  assign tx_valid = (head < tail);
  assign tx_data  = txq[head[7:0]];

  // Slave response pattern
  function automatic logic [7:0] resp_byte(input int k);
    return 8'(k * 59 + 113);
  endfunction

  int sk = 0, sb = 0;
  logic [7:0] mosi_sh = 8'd0;
  logic [7:0] mosi_log [0:1023];
  int mosi_n = 0;
  assign miso = resp_byte(sk)[7 - sb];

  always @(posedge sclk) begin
    if (sb == 7) begin
      mosi_log[mosi_n[9:0]] <= {mosi_sh[6:0], mosi};
      mosi_n <= mosi_n + 1;
      sb <= 0;
      sk <= sk + 1;
    end else begin
      sb <= sb + 1;
    end
    mosi_sh <= {mosi_sh[6:0], mosi};
  end

  // Port monitor
  logic [31:0] rx_log [0:255];
  logic        xch_log [0:255];
  int rx_n = 0, we_n = 0, done_cnt = 0, ovf_cnt = 0, hi_cnt = 0, last_hi = 0;
  always @(posedge clk) begin
    if (tx_pop) head <= head + 1;
    if (rx_push) begin rx_log[rx_n[7:0]] <= rx_data; rx_n <= rx_n + 1; end
    if (rx_push || evt_ovf) begin xch_log[we_n[7:0]] <= xch_busy; we_n <= we_n + 1; end
    if (evt_done) done_cnt <= done_cnt + 1;
    if (evt_ovf) ovf_cnt <= ovf_cnt + 1;
    if (sclk) hi_cnt <= hi_cnt + 1;
    else if (hi_cnt != 0) begin last_hi <= hi_cnt; hi_cnt <= 0; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference model state
  int m_rem = 0, m_k = 0;
  bit m_xch = 0;
  logic [7:0]  e_mosi [0:1023];
  logic [31:0] e_rx   [0:255];
  bit          e_xch  [0:255];

  task automatic run_case(input string tag, input int nw, input bit full);
    int mb, rb, wbse, db, ob, h, ne, nr, nx, de, oe, wbits;
    bit multi;
    logic [31:0] w, r;
    for (int i = 0; i < nw; i++) txq[(tail + i) % 256] = $urandom;
    tail += nw;
    rx_full = full;
    mb = mosi_n; rb = rx_n; wbse = we_n; db = done_cnt; ob = ovf_cnt;
    // expected behaviour from the requirements
    multi = cfg_master && !cfg_imm && cfg_hold[cfg_chan];
    h = head; ne = 0; nr = 0; nx = 0; de = 0; oe = 0;
    if (cfg_master) begin
      if (h == tail) de = 1;
      while (h < tail) begin
        w = txq[h % 256]; h++;
        if (m_rem <= 0) begin m_rem = int'(cfg_len) + 1; if (multi) m_xch = 1; end  // R2, R6
        wbits = (m_rem > 32) ? 32 : m_rem;
        r = 32'd0;
        for (int i = 0; i < 4; i++) begin  // R3, R4
          e_mosi[ne] = w[8*i +: 8]; ne++;
          r[8*i +: 8] = resp_byte(m_k); m_k++;
          wbits -= 8; m_rem -= 8;
          if (wbits <= 0) break;
        end
        e_xch[nx] = m_xch; nx++;
        if (full) oe++; else begin e_rx[nr] = r; nr++; end  // R5
        if (m_rem <= 0) m_xch = 0;  // R7
        if ((m_rem <= 0 && !multi) || h == tail) begin de = 1; break; end  // R7, R8
      end
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 20000 && busy; c++) @(negedge clk);
    if (busy) check(0, {tag, " R8 watchdog idle"}, 1, 0);
    @(negedge clk);
    @(negedge clk);
    check(head == h, {tag, " R7 words consumed"}, head, h);
    check(done_cnt - db == de, {tag, " R8 done pulses"}, done_cnt - db, de);
    check(ovf_cnt - ob == oe, {tag, " R5 overflow pulses"}, ovf_cnt - ob, oe);
    check(mosi_n - mb == ne, {tag, " R3 byte count"}, mosi_n - mb, ne);
    for (int i = 0; i < ne && i < mosi_n - mb; i++)
      check(mosi_log[mb + i] == e_mosi[i], {tag, " R3 mosi byte"}, mosi_log[mb + i], e_mosi[i]);
    check(rx_n - rb == nr, {tag, " R5 push count"}, rx_n - rb, nr);
    for (int i = 0; i < nr && i < rx_n - rb; i++)
      check(rx_log[rb + i] == e_rx[i], {tag, " R4 rx word"}, rx_log[rb + i], e_rx[i]);
    for (int i = 0; i < nx && i < we_n - wbse; i++)
      check(xch_log[wbse + i] == e_xch[i], {tag, " R6 xch at word end"}, xch_log[wbse + i], e_xch[i]);
    check(xch_busy == m_xch, {tag, " R7 xch after stop"}, xch_busy, m_xch);
  endtask

  initial begin
    #(200000 * 4);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!sclk && !busy && !xch_busy, "R1 idle outputs", {sclk, busy, xch_busy}, 0);
    check(!tx_pop && !rx_push && !evt_done && !evt_ovf, "R1 strobes",
          {tx_pop, rx_push, evt_done, evt_ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: empty FIFO start
    run_case("empty", 0, 0);
    // R7: 32-bit bursts, single-burst mode, one word per start
    cfg_len = 12'd31; cfg_hold = 4'd0;
    run_case("single32", 3, 0);
    run_case("single32b", 0, 0);
    // R2 carry-over: 72-bit burst across words, single-burst mode
    cfg_len = 12'd71;
    run_case("carry72", 1, 0);
    run_case("carry72b", 0, 0);
    // R6: multi-burst, 72-bit bursts, slower clock (R10)
    cfg_div = 8'd3; cfg_chan = 2'd2; cfg_hold = 4'b0100;
    run_case("multi72", 5, 0);
    check(last_hi == 4, "R10 sclk high time", last_hi, 4);
    // R4: 12-bit bursts, two bytes per word
    cfg_len = 12'd11; cfg_div = 8'd0;
    run_case("short12", 3, 0);
    check(last_hi == 1, "R10 sclk high time div0", last_hi, 1);
    // R5: overflow
    cfg_len = 12'd31; cfg_hold = 4'd0;
    run_case("ovf", 1, 1);
    // R6: immediate-start disables multi-burst
    cfg_imm = 1'b1; cfg_hold = 4'b1111;
    run_case("imm", 2, 0);
    run_case("imm_b", 0, 0);
    cfg_imm = 1'b0;
    // R9: not master
    cfg_master = 1'b0;
    begin
      int h0, d0;
      h0 = head; d0 = done_cnt;
      txq[tail % 256] = 32'hA5A5_5A5A; tail++;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      check(!busy, "R9 stays idle", busy, 0);
      repeat (4) @(negedge clk);
      check(head == h0, "R9 nothing popped", head, h0);
      check(done_cnt == d0, "R9 no done", done_cnt, d0);
    end
    cfg_master = 1'b1;
    run_case("flush", 0, 0);
    // Random runs
    for (int it = 0; it < 24; it++) begin
      cfg_len    = 12'($urandom_range(0, 100));
      cfg_master = ($urandom % 8) != 0;
      cfg_imm    = ($urandom % 4) == 0;
      cfg_chan   = 2'($urandom);
      cfg_hold   = 4'($urandom);
      cfg_div    = 8'($urandom_range(0, 3));
      run_case("rand", $urandom_range(0, 4), ($urandom % 4) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule